// File: doc/BRIEF.md
# Three-Bit Uniform Group Detector

The block reads a serial stream at one bit per clock and cuts it into back-to-back, non-overlapping frames of three bits, most significant bit first. On the clock that carries the last bit of a frame, it raises its single output if the frame is 000 or 111. All three bits must agree, in either polarity. On every other clock the output stays low.

A synchronous reset places the detector at a frame boundary and discards any partly received frame. The first bit sampled after reset is released is the first bit of a new frame. A frame whose first two bits already differ is still carried through its third bit, so frame alignment is never lost. The output depends on the current input bit as well as the stored state: it is a Mealy output and is valid during the cycle of the third bit.

Top module: `uniform_group_detector`

## Requirements
- R1: Reset `rst` is synchronous and active high. While it is high, `match` is low for any value of `din`, even if a partial frame was in progress.
- R2: Bits are sampled on the rising clock edge, one per cycle, in consecutive frames of three. The first sample with `rst` low starts a frame, and that first bit is the most significant bit of the frame.
- R3: On the third bit of a frame whose bits are 0,0,0, `match` is high during that cycle.
- R4: On the third bit of a frame whose bits are 1,1,1, `match` is high during that cycle.
- R5: On the third bit of any of the six frames whose bits are not all equal, `match` is low.
- R6: During the first and second bits of every frame, `match` is low.
- R7: A frame whose first two bits differ still consumes its third bit before a new frame begins. Frames never overlap, so a run of equal bits that crosses a frame boundary is not reported.
- R8: A reset applied in the middle of a frame discards the bits already received. The next frame is judged only on the bits that follow the reset.
- R9: `match` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; realigns to a frame start |
| din | input | 1 | Serial data bit, sampled every clock |
| match | output | 1 | High on the third bit of a 000 or 111 frame |

## Verification
The bench aims at frame alignment. It feeds a frame such as 011 followed by 111, where the run of ones crosses the boundary. A detector that slides its window, or that restarts early after an early mismatch, would fire one or two bits too soon. It also resets in the middle of a 11 prefix while holding `din` at 1. A design that failed to gate its combinational output would pulse during reset, and one that kept the stale prefix would flag the first bit that follows. Every frame value is sent, both in order and shuffled, so that a state machine that mixes up the two polarities or the two leading-pair states would flag a mixed frame or miss a uniform one.

// File: rtl/ugd_pkg.sv
package ugd_pkg;

   localparam int FRAME_BITS = 3;
   localparam int STATE_W    = 3;

   // one state per distinct prefix history inside the current frame
   typedef enum logic [STATE_W-1:0] {
      ST_IDLE  = 3'd0,   // at a frame boundary
      ST_LEAD0 = 3'd1,   // first bit was 0
      ST_LEAD1 = 3'd2,   // first bit was 1
      ST_PAIR0 = 3'd3,   // first two bits were 00
      ST_PAIR1 = 3'd4,   // first two bits were 11
      ST_SPOIL = 3'd5    // frame already known to be mixed
   } ugd_state_e;

endpackage

// File: rtl/ugd_next.sv
module ugd_next
   import ugd_pkg::*;
(
   input  ugd_state_e cur,
   input  logic       bit_in,
   output ugd_state_e nxt,
   output logic       hit
);

   always_comb begin
      nxt = ST_IDLE;
      hit = 1'b0;
      unique case (cur)
         ST_IDLE:  nxt = bit_in ? ST_LEAD1 : ST_LEAD0;
         ST_LEAD0: nxt = bit_in ? ST_SPOIL : ST_PAIR0;
         ST_LEAD1: nxt = bit_in ? ST_PAIR1 : ST_SPOIL;
         ST_PAIR0: begin
            nxt = ST_IDLE;
            hit = ~bit_in;
         end
         ST_PAIR1: begin
            nxt = ST_IDLE;
            hit = bit_in;
         end
         ST_SPOIL: nxt = ST_IDLE;
         default:  nxt = ST_IDLE;
      endcase
   end

endmodule

// File: rtl/ugd_state_reg.sv
module ugd_state_reg
   import ugd_pkg::*;
#(
   parameter ugd_state_e INIT = ST_IDLE
) (
   input  logic       clk,
   input  logic       rst,
   input  ugd_state_e d,
   output ugd_state_e q
);

   always_ff @(posedge clk) begin
      if (rst) q <= INIT;
      else     q <= d;
   end

endmodule

// File: rtl/uniform_group_detector.sv
module uniform_group_detector
   import ugd_pkg::*;
#(
   parameter int GROUP_LEN = FRAME_BITS
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic match
);

   generate
      if (GROUP_LEN != 3) begin : g_len_check
         $error("uniform_group_detector: only three-bit frames are supported");
      end
   endgenerate

   ugd_state_e cur_state;
   ugd_state_e nxt_state;
   logic       raw_hit;

   ugd_next u_next (
      .cur    (cur_state),
      .bit_in (din),
      .nxt    (nxt_state),
      .hit    (raw_hit)
   );

   ugd_state_reg #(.INIT(ST_IDLE)) u_reg (
      .clk (clk),
      .rst (rst),
      .d   (nxt_state),
      .q   (cur_state)
   );

   // the combinational hit must not escape while a frame is being dropped
   assign match = raw_hit & ~rst;

endmodule

// File: rtl/ugd_checker.sv
module ugd_checker
   import ugd_pkg::*;
(
   input logic       clk,
   input logic       rst,
   input logic       din,
   input logic       match,
   input ugd_state_e state
);

   logic [1:0] pos;

   always_ff @(posedge clk) begin
      if (rst)           pos <= 2'd0;
      else if (pos == 2) pos <= 2'd0;
      else               pos <= pos + 2'd1;
   end

   AST_QUIET_IN_RESET: assert property (@(posedge clk) rst |-> !match); // R1
   AST_ALIGNED_START: assert property (@(posedge clk) disable iff (rst)
      (pos == 2'd0) |-> (state == ST_IDLE)); // R2
   AST_ZEROS_FLAGGED: assert property (@(posedge clk) disable iff (rst)
      (pos == 2'd2 && !din && !$past(din) && !$past(din, 2)) |-> match); // R3
   AST_ONES_FLAGGED: assert property (@(posedge clk) disable iff (rst)
      (pos == 2'd2 && din && $past(din) && $past(din, 2)) |-> match); // R4
   AST_MIXED_SILENT: assert property (@(posedge clk) disable iff (rst)
      (pos == 2'd2 && match) |-> (din == $past(din) && din == $past(din, 2))); // R5
   AST_EARLY_SILENT: assert property (@(posedge clk) disable iff (rst)
      (pos != 2'd2) |-> !match); // R6
   AST_RESET_DROPS: assert property (@(posedge clk) rst |=> (state == ST_IDLE)); // R8
   AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
      match |=> !match); // R9

endmodule

bind uniform_group_detector ugd_checker u_chk (
   .clk   (clk),
   .rst   (rst),
   .din   (din),
   .match (match),
   .state (cur_state)
);

// File: tb/tb_uniform_group_detector.sv
`timescale 1ns/1ps
module tb_uniform_group_detector;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic din = 1'b0;
   logic match;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   bit    exp_q[$];
   string tag_q[$];

   always #2.5 clk = ~clk;

   uniform_group_detector dut (
      .clk   (clk),
      .rst   (rst),
      .din   (din),
      .match (match)
   );

   task automatic check(input bit act, input bit exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: match=%0b expected %0b at %0t", tag, act, exp, $time);
      end
   endtask

   // driver: one bit per clock, applied at the falling edge
   task automatic drive_bit(input bit b, input bit exp, input string tag);
      @(negedge clk);
      rst = 1'b0;
      din = b;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
   endtask

   // reference model: a frame is flagged only on its last bit and only if uniform
   task automatic send_group(input logic [2:0] g, input string early_tag = "R6");
      for (int i = 2; i >= 0; i--) begin
         if (i != 0)          drive_bit(g[i], 1'b0, early_tag);
         else if (g == 3'b000) drive_bit(g[i], 1'b1, "R3");
         else if (g == 3'b111) drive_bit(g[i], 1'b1, "R4");
         else                  drive_bit(g[i], 1'b0, "R5");
      end
   endtask

   task automatic reset_cycle(input bit b);
      @(negedge clk);
      rst = 1'b1;
      din = b;
      #1 check(match, 1'b0, "R1");
   endtask

   // monitor: compares each queued expectation shortly after the bit is applied
   bit prev_match = 1'b0;
   always begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
         string t;
         bit    e;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(match, e, t);
      end
      if (prev_match && !rst) check(match, 1'b0, "R9");
      prev_match = match;
   end

   initial begin
      repeat (2) @(negedge clk);
      reset_cycle(1'b0);
      reset_cycle(1'b1);

      // R2: every frame value in order, straight after reset
      for (int g = 0; g < 8; g++) send_group(3'(g), "R2");

      // R7: runs of ones and zeros that cross a frame boundary
      send_group(3'b011, "R7");
      send_group(3'b111, "R7");
      send_group(3'b100, "R7");
      send_group(3'b000, "R7");
      send_group(3'b110, "R7");
      send_group(3'b001, "R7");

      // R8 and R1: reset after a 11 prefix with din high, then a fresh frame
      drive_bit(1'b1, 1'b0, "R6");
      drive_bit(1'b1, 1'b0, "R6");
      reset_cycle(1'b1);
      drive_bit(1'b1, 1'b0, "R8");
      drive_bit(1'b0, 1'b0, "R8");
      drive_bit(1'b0, 1'b0, "R8");
      drive_bit(1'b0, 1'b0, "R8");
      drive_bit(1'b0, 1'b0, "R8");
      drive_bit(1'b0, 1'b1, "R8");

      // reset after a single 0 prefix, then 111
      drive_bit(1'b0, 1'b0, "R6");
      reset_cycle(1'b0);
      send_group(3'b111, "R8");

      // shuffled frames: all eight values, in random order
      for (int r = 0; r < 6; r++) begin
         logic [2:0] perm[8];
         for (int k = 0; k < 8; k++) perm[k] = 3'(k);
         for (int k = 7; k > 0; k--) begin
            int j;
            logic [2:0] tmp;
            j = int'($urandom_range(k, 0));
            tmp = perm[k]; perm[k] = perm[j]; perm[j] = tmp;
         end
         for (int k = 0; k < 8; k++) send_group(perm[k]);
      end

      // back-to-back uniform frames keep pulsing once per frame
      send_group(3'b000);
      send_group(3'b000);
      send_group(3'b111);

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

endmodule